// File: doc/BRIEF.md
# AXI Transaction ID Compressor

This block sits on one AXI address channel (read or write; a system uses two copies) between a fabric that issues 12-bit transaction IDs and a target port that accepts only 3-bit IDs. Each request is given an outgoing ID slot. A slot either belongs permanently to one configured incoming ID (fixed mode) or is handed out on demand to whichever incoming ID asks first (dynamic mode). Every slot also supplies a 2-bit window selector, which replaces the two top address bits so that the request lands in one 1 GiB quarter of the 4 GiB space, and a 5-bit user sideband value.

The request stream is valid/ready on both sides and passes straight through without storage. The block asserts `out_valid` only when `req_valid` is high and a slot is available, and it never makes `out_valid` depend on `out_ready`. `req_ready` follows `out_ready` gated by the same availability. When no slot is available, both go low and the request waits, and the upstream master must hold it stable. A transfer counts as issued in a cycle where `req_valid`, `req_ready` and `out_valid`/`out_ready` are all high. Completions come back as a one-cycle pulse carrying the outgoing ID. Configuration uses a plain write strobe that takes effect at the next clock edge.

Top module: `axi_id_squeezer`

## Requirements
- R1: After reset, slot 2 is fixed to incoming ID 0x004 with window 0 and user 0. Slots 3 to 7 are dynamic and idle. The shared dynamic window and shared user value are both 0, and `out_valid` is low while `req_valid` is low.
- R2: A request whose ID equals the tag of a fixed slot (2 to 6) goes out on that slot, using that slot's own window and user value. The lowest such slot wins, and a fixed match takes precedence over any dynamic slot.
- R3: Outgoing IDs 0 and 1 are never issued, and configuration writes that address them have no effect.
- R4: A configuration write that makes slot 7 fixed is ignored as a whole, so slot 7 stays dynamic with its old settings. A dynamic-mode write to slot 7 is accepted.
- R5: While a dynamic slot has outstanding transactions for an incoming ID, further requests with that ID reuse the same slot.
- R6: A request with no fixed match and no bound dynamic slot takes the lowest-numbered dynamic slot that has zero outstanding transactions. That slot then becomes bound to the request's ID.
- R7: Each completion (`done_valid` with `done_id`) lowers the outstanding count of that slot by one. A dynamic slot whose count returns to zero is free for any ID.
- R8: When the chosen slot already holds 15 outstanding transactions, or no slot can be found, `out_valid` and `req_ready` are both low. In that case no slot state changes due to the request.
- R9: `out_addr[31:30]` equals the selected window (the fixed slot's own, or the shared one for dynamic slots), and `out_addr[29:0]` equals `req_addr[29:0]`.
- R10: `out_user` is the slot's own user value for fixed slots and the shared value for dynamic slots. The exception is an incoming ID with bit 11 = 0 and bits [2:0] = 000 (the fabric bridge), which keeps its own `req_user`.
- R11: `out_valid` = `req_valid` AND mapped, and `req_ready` = `out_ready` AND mapped. A slot is claimed only in a cycle where the request is actually accepted.
- R12: A completion for a slot with zero outstanding transactions is ignored. A completion and an acceptance on the same slot in the same cycle leave the count unchanged, except when the count was zero, in which case it becomes one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Incoming request valid |
| req_ready | output | 1 | Incoming request accepted |
| req_id | input | 12 | Incoming transaction ID |
| req_addr | input | 32 | Incoming address |
| req_user | input | 5 | Incoming user sideband |
| out_valid | output | 1 | Outgoing request valid |
| out_ready | input | 1 | Downstream ready |
| out_id | output | 3 | Outgoing compressed ID |
| out_addr | output | 32 | Address with window bits applied |
| out_user | output | 5 | Outgoing user sideband |
| done_valid | input | 1 | Completion pulse |
| done_id | input | 3 | Outgoing ID of the completed transaction |
| cfg_we | input | 1 | Slot configuration write |
| cfg_slot | input | 3 | Slot addressed by the write |
| cfg_fixed | input | 1 | 1 = fixed mode, 0 = dynamic mode |
| cfg_in_id | input | 12 | Incoming ID bound in fixed mode |
| cfg_page | input | 2 | Window selector (slot write or shared write) |
| cfg_user | input | 5 | User value (slot write or shared write) |
| cfg_dyn_we | input | 1 | Write of the shared dynamic window and user |

## Verification
The bench targets the edges of slot accounting. It fills every dynamic slot and then checks that a new ID stalls instead of overwriting a busy binding, and that a released slot is the one handed out next. It also drives one ID to 15 outstanding transactions; a counter that wrapped would let a sixteenth request through under the same ID. Further directed cases cover writes to reserved IDs and a fixed-mode write to slot 7, which a careless decoder would accept and which would then steal traffic. They also cover bridge IDs, which would lose their own user value if the pass-through test were wrong. A long random phase then mixes back-pressure, stray completions and reconfiguration, and compares every output against a behavioural model on every clock.

// File: rtl/idsq_pkg.sv
package idsq_pkg;
  typedef enum logic {MODE_DYN = 1'b0, MODE_FIX = 1'b1} slot_mode_e;

  // Fabric-bridge IDs keep their own sideband value: top bit clear, low three bits zero.
  function automatic logic is_bridge_id(input logic [11:0] id);
    return (id[11] == 1'b0) && (id[2:0] == 3'b000);
  endfunction
endpackage

// File: rtl/idsq_slot.sv
module idsq_slot
  import idsq_pkg::*;
#(
  parameter int IN_W    = 12,
  parameter int PAGE_W  = 2,
  parameter int USER_W  = 5,
  parameter int CNT_W   = 4,
  parameter bit CAN_FIX = 1'b1,
  parameter bit RST_FIX = 1'b0,
  parameter logic [IN_W-1:0] RST_TAG = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_fixed,
  input  logic [IN_W-1:0]   cfg_tag,
  input  logic [PAGE_W-1:0] cfg_page,
  input  logic [USER_W-1:0] cfg_user,
  input  logic              alloc,
  input  logic [IN_W-1:0]   alloc_id,
  input  logic              retire,
  output logic              is_fixed,
  output logic [IN_W-1:0]   tag,
  output logic [PAGE_W-1:0] page,
  output logic [USER_W-1:0] user,
  output logic [CNT_W-1:0]  count
);
  slot_mode_e mode_q;
  logic       cfg_ok;
  logic       dec;

  assign cfg_ok   = cfg_en && (CAN_FIX || !cfg_fixed);
  assign dec      = retire && (count != '0);
  assign is_fixed = (mode_q == MODE_FIX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= RST_FIX ? MODE_FIX : MODE_DYN;
      tag    <= RST_TAG;
      page   <= '0;
      user   <= '0;
      count  <= '0;
    end else begin
      if (alloc && !is_fixed) tag <= alloc_id;
      if (cfg_ok) begin
        mode_q <= cfg_fixed ? MODE_FIX : MODE_DYN;
        page   <= cfg_page;
        user   <= cfg_user;
        if (cfg_fixed) tag <= cfg_tag;
      end
      if (alloc && !dec)      count <= count + 1'b1;
      else if (!alloc && dec) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/idsq_pick.sv
module idsq_pick #(
  parameter int IN_W      = 12,
  parameter int OUT_W     = 3,
  parameter int CNT_W     = 4,
  parameter int FIRST     = 2,
  parameter int FIX_LAST  = 6,
  localparam int NSLOT    = 1 << OUT_W
) (
  input  logic [IN_W-1:0]  req_id,
  input  logic             fixed_v [NSLOT],
  input  logic [IN_W-1:0]  tag_v   [NSLOT],
  input  logic [CNT_W-1:0] count_v [NSLOT],
  output logic             mapped,
  output logic [OUT_W-1:0] sel
);
  logic             fix_hit, bind_hit, free_hit;
  logic [OUT_W-1:0] fix_sel, bind_sel, free_sel;

  always_comb begin
    fix_hit  = 1'b0; fix_sel  = '0;
    bind_hit = 1'b0; bind_sel = '0;
    free_hit = 1'b0; free_sel = '0;
    for (int s = FIRST; s < NSLOT; s++) begin
      if (s <= FIX_LAST && fixed_v[s] && tag_v[s] == req_id && !fix_hit) begin
        fix_hit = 1'b1;
        fix_sel = OUT_W'(s);
      end
      if (!fixed_v[s] && count_v[s] != '0 && tag_v[s] == req_id && !bind_hit) begin
        bind_hit = 1'b1;
        bind_sel = OUT_W'(s);
      end
      if (!fixed_v[s] && count_v[s] == '0 && !free_hit) begin
        free_hit = 1'b1;
        free_sel = OUT_W'(s);
      end
    end
    if (fix_hit)       sel = fix_sel;
    else if (bind_hit) sel = bind_sel;
    else               sel = free_sel;
    mapped = (fix_hit || bind_hit || free_hit) && !(&count_v[sel]);
  end
endmodule

// File: rtl/axi_id_squeezer.sv
module axi_id_squeezer
  import idsq_pkg::*;
#(
  parameter int IN_W     = 12,
  parameter int OUT_W    = 3,
  parameter int ADDR_W   = 32,
  parameter int PAGE_W   = 2,
  parameter int USER_W   = 5,
  parameter int CNT_W    = 4,
  parameter int FIRST    = 2,
  parameter int FIX_LAST = 6,
  parameter int DBG_SLOT = 2,
  parameter logic [IN_W-1:0] DBG_ID = 12'h004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IN_W-1:0]   req_id,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [USER_W-1:0] req_user,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_id,
  output logic [ADDR_W-1:0] out_addr,
  output logic [USER_W-1:0] out_user,
  input  logic              done_valid,
  input  logic [OUT_W-1:0]  done_id,
  input  logic              cfg_we,
  input  logic [OUT_W-1:0]  cfg_slot,
  input  logic              cfg_fixed,
  input  logic [IN_W-1:0]   cfg_in_id,
  input  logic [PAGE_W-1:0] cfg_page,
  input  logic [USER_W-1:0] cfg_user,
  input  logic              cfg_dyn_we
);
  localparam int NSLOT = 1 << OUT_W;
  localparam int LOW_W = ADDR_W - PAGE_W;

  logic              fixed_v [NSLOT];
  logic [IN_W-1:0]   tag_v   [NSLOT];
  logic [PAGE_W-1:0] page_v  [NSLOT];
  logic [USER_W-1:0] user_v  [NSLOT];
  logic [CNT_W-1:0]  count_v [NSLOT];

  logic              mapped;
  logic [OUT_W-1:0]  sel;
  logic              accept;
  logic [PAGE_W-1:0] dyn_page;
  logic [USER_W-1:0] dyn_user;
  logic [PAGE_W-1:0] page_sel;
  logic [USER_W-1:0] user_sel;

  assign accept = req_valid && out_ready && mapped;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dyn_page <= '0;
      dyn_user <= '0;
    end else if (cfg_dyn_we) begin
      dyn_page <= cfg_page;
      dyn_user <= cfg_user;
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    if (s < FIRST) begin : g_resv
      assign fixed_v[s] = 1'b0;
      assign tag_v[s]   = '0;
      assign page_v[s]  = '0;
      assign user_v[s]  = '0;
      assign count_v[s] = '0;
    end else begin : g_live
      idsq_slot #(
        .IN_W    (IN_W),
        .PAGE_W  (PAGE_W),
        .USER_W  (USER_W),
        .CNT_W   (CNT_W),
        .CAN_FIX (s <= FIX_LAST),
        .RST_FIX (s == DBG_SLOT),
        .RST_TAG ((s == DBG_SLOT) ? DBG_ID : '0)
      ) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_we && cfg_slot == OUT_W'(s)),
        .cfg_fixed(cfg_fixed),
        .cfg_tag  (cfg_in_id),
        .cfg_page (cfg_page),
        .cfg_user (cfg_user),
        .alloc    (accept && sel == OUT_W'(s)),
        .alloc_id (req_id),
        .retire   (done_valid && done_id == OUT_W'(s)),
        .is_fixed (fixed_v[s]),
        .tag      (tag_v[s]),
        .page     (page_v[s]),
        .user     (user_v[s]),
        .count    (count_v[s])
      );
    end
  end

  idsq_pick #(
    .IN_W    (IN_W),
    .OUT_W   (OUT_W),
    .CNT_W   (CNT_W),
    .FIRST   (FIRST),
    .FIX_LAST(FIX_LAST)
  ) u_pick (
    .req_id (req_id),
    .fixed_v(fixed_v),
    .tag_v  (tag_v),
    .count_v(count_v),
    .mapped (mapped),
    .sel    (sel)
  );

  always_comb begin
    page_sel = fixed_v[sel] ? page_v[sel] : dyn_page;
    user_sel = fixed_v[sel] ? user_v[sel] : dyn_user;
    if (is_bridge_id(req_id)) user_sel = req_user;
  end

  assign out_valid = req_valid && mapped;
  assign req_ready = out_ready && mapped;
  assign out_id    = sel;
  assign out_addr  = {page_sel, req_addr[LOW_W-1:0]};
  assign out_user  = user_sel;
endmodule

// File: rtl/idsq_chk.sv
module idsq_chk #(
  parameter int IN_W   = 12,
  parameter int OUT_W  = 3,
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 2,
  parameter int USER_W = 5,
  parameter int FIRST  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [IN_W-1:0]   req_id,
  input logic [ADDR_W-1:0] req_addr,
  input logic [USER_W-1:0] req_user,
  input logic              out_valid,
  input logic              out_ready,
  input logic [OUT_W-1:0]  out_id,
  input logic [ADDR_W-1:0] out_addr,
  input logic [USER_W-1:0] out_user
);
  localparam int LOW_W = ADDR_W - PAGE_W;

  // R3
  no_reserved_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_id >= OUT_W'(FIRST)));

  // R11
  accept_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (out_valid && out_ready));

  // R11
  valid_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> req_valid);

  // R9
  low_addr_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_addr[LOW_W-1:0] == req_addr[LOW_W-1:0]));

  // R10
  bridge_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !req_id[IN_W-1] && req_id[2:0] == 3'b000) |-> (out_user == req_user));
endmodule

bind axi_id_squeezer idsq_chk #(
  .IN_W  (IN_W),
  .OUT_W (OUT_W),
  .ADDR_W(ADDR_W),
  .PAGE_W(PAGE_W),
  .USER_W(USER_W),
  .FIRST (FIRST)
) u_idsq_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_id   (req_id),
  .req_addr (req_addr),
  .req_user (req_user),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_id   (out_id),
  .out_addr (out_addr),
  .out_user (out_user)
);

// File: tb/test_axi_id_squeezer.sv
module test_axi_id_squeezer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [11:0] req_id;
  logic [31:0] req_addr;
  logic [4:0]  req_user;
  logic        out_valid, out_ready;
  logic [2:0]  out_id;
  logic [31:0] out_addr;
  logic [4:0]  out_user;
  logic        done_valid;
  logic [2:0]  done_id;
  logic        cfg_we, cfg_fixed, cfg_dyn_we;
  logic [2:0]  cfg_slot;
  logic [11:0] cfg_in_id;
  logic [1:0]  cfg_page;
  logic [4:0]  cfg_user;

  int nchk = 0;
  int nerr = 0;
  string cur_req = "R1";

  // behavioural model state
  int mfix [8];
  int mtag [8];
  int mpage[8];
  int muser[8];
  int mcnt [8];
  int dpage, duser;

  always #5 clk = ~clk;

  axi_id_squeezer i_axi_id_squeezer (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id),
    .req_addr(req_addr), .req_user(req_user),
    .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id),
    .out_addr(out_addr), .out_user(out_user),
    .done_valid(done_valid), .done_id(done_id),
    .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_fixed(cfg_fixed),
    .cfg_in_id(cfg_in_id), .cfg_page(cfg_page), .cfg_user(cfg_user),
    .cfg_dyn_we(cfg_dyn_we)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  function automatic int model_pick(input int id);
    int s = -1;
    for (int k = 2; k <= 6; k++) if (s < 0 && mfix[k] != 0 && mtag[k] == id) s = k;
    for (int k = 2; k <= 7; k++) if (s < 0 && mfix[k] == 0 && mcnt[k] > 0 && mtag[k] == id) s = k;
    for (int k = 2; k <= 7; k++) if (s < 0 && mfix[k] == 0 && mcnt[k] == 0) s = k;
    if (s >= 0 && mcnt[s] >= 15) s = -1;
    return s;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 8; k++) begin
      mfix[k] = 0; mtag[k] = 0; mpage[k] = 0; muser[k] = 0; mcnt[k] = 0;
    end
    mfix[2] = 1; mtag[2] = 12'h004;
    dpage = 0; duser = 0;
  endtask

  // compare against the model, advance one clock, update the model
  task automatic cycle();
    int  s;
    bit  acc;
    int  ep, eu;
    int  old_cnt[8];
    #1;
    s = model_pick(int'(req_id));
    chk(out_valid == (req_valid && s >= 0), "out_valid", out_valid, req_valid && s >= 0);
    chk(req_ready == (out_ready && s >= 0), "req_ready", req_ready, out_ready && s >= 0);
    if (req_valid && s >= 0) begin
      ep = mfix[s] != 0 ? mpage[s] : dpage;
      eu = mfix[s] != 0 ? muser[s] : duser;
      if (req_id[11] == 1'b0 && req_id[2:0] == 3'd0) eu = int'(req_user);
      chk(out_id == 3'(s), "out_id", out_id, s);
      chk(out_addr == {2'(ep), req_addr[29:0]}, "out_addr", out_addr, {2'(ep), req_addr[29:0]});
      chk(out_user == 5'(eu), "out_user", out_user, eu);
    end
    acc = req_valid && out_ready && s >= 0;
    @(posedge clk);
    for (int k = 0; k < 8; k++) old_cnt[k] = mcnt[k];
    if (acc && mfix[s] == 0) mtag[s] = int'(req_id);
    for (int k = 0; k < 8; k++) begin
      if (acc && s == k) mcnt[k]++;
      if (done_valid && int'(done_id) == k && old_cnt[k] > 0) mcnt[k]--;
    end
    if (cfg_we && cfg_slot >= 3'd2 && !(cfg_slot == 3'd7 && cfg_fixed)) begin
      mfix[cfg_slot]  = cfg_fixed;
      mpage[cfg_slot] = int'(cfg_page);
      muser[cfg_slot] = int'(cfg_user);
      if (cfg_fixed) mtag[cfg_slot] = int'(cfg_in_id);
    end
    if (cfg_dyn_we) begin
      dpage = int'(cfg_page);
      duser = int'(cfg_user);
    end
    @(negedge clk);
    req_valid = 0; done_valid = 0; cfg_we = 0; cfg_dyn_we = 0;
  endtask

  task automatic set_req(input logic [11:0] id, input logic [31:0] a, input logic [4:0] u);
    req_valid = 1; req_id = id; req_addr = a; req_user = u;
  endtask

  task automatic cfg_slot_wr(input int s, input bit f, input int id, input int p, input int u);
    cfg_we = 1; cfg_slot = 3'(s); cfg_fixed = f; cfg_in_id = 12'(id);
    cfg_page = 2'(p); cfg_user = 5'(u);
    cycle();
  endtask

  task automatic complete(input int s);
    done_valid = 1; done_id = 3'(s);
    cycle();
  endtask

  // drive a request, check expected id/addr/user directly, then run the cycle
  task automatic send_exp(input logic [11:0] id, input logic [31:0] a, input logic [4:0] u,
                          input bit ev, input int eid, input logic [31:0] ea, input int eu);
    set_req(id, a, u);
    #1;
    chk(out_valid == ev, "direct out_valid", out_valid, ev);
    if (ev) begin
      chk(out_id == 3'(eid), "direct out_id", out_id, eid);
      chk(out_addr == ea, "direct out_addr", out_addr, ea);
      chk(out_user == 5'(eu), "direct out_user", out_user, eu);
    end
    cycle();
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_id = 0; req_addr = 0; req_user = 0;
    out_ready = 1; done_valid = 0; done_id = 0; cfg_we = 0; cfg_slot = 0;
    cfg_fixed = 0; cfg_in_id = 0; cfg_page = 0; cfg_user = 0; cfg_dyn_we = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state, debug ID on slot 2
    cur_req = "R1";
    #1 chk(out_valid == 1'b0, "idle out_valid", out_valid, 0);
    send_exp(12'h004, 32'h0000_1000, 5'h11, 1, 2, 32'h0000_1000, 0);
    complete(2);

    // R2: fixed slot with own window/user; R9 address window
    cur_req = "R2";
    cfg_slot_wr(3, 1, 12'h123, 2, 5'h0A);
    cur_req = "R9";
    send_exp(12'h123, 32'h1234_5678, 5'h01, 1, 3, 32'h9234_5678, 5'h0A);

    // R3: writes to reserved ID ignored; R6 lowest free dynamic
    cur_req = "R3";
    cfg_slot_wr(1, 1, 12'h055, 1, 5'h07);
    cur_req = "R6";
    send_exp(12'h055, 32'h0000_0040, 5'h02, 1, 4, 32'h0000_0040, 0);

    // R5: reuse of bound dynamic slot
    cur_req = "R5";
    send_exp(12'h055, 32'h0000_0080, 5'h02, 1, 4, 32'h0000_0080, 0);
    send_exp(12'h077, 32'h0000_0100, 5'h02, 1, 5, 32'h0000_0100, 0);

    // R4: slot 7 cannot be made fixed
    cur_req = "R4";
    cfg_slot_wr(7, 1, 12'h066, 1, 5'h09);
    send_exp(12'h066, 32'h4000_0000, 5'h03, 1, 6, 32'h0000_0000, 0);
    send_exp(12'h099, 32'h0000_0200, 5'h03, 1, 7, 32'h0000_0200, 0);

    // R8: no free slot stalls
    cur_req = "R8";
    set_req(12'h0AA, 32'h0, 5'h0);
    #1;
    chk(out_valid == 1'b0, "stall out_valid", out_valid, 0);
    chk(req_ready == 1'b0, "stall req_ready", req_ready, 0);
    cycle();

    // R7: release then reuse
    cur_req = "R7";
    complete(5);
    send_exp(12'h0AA, 32'h0000_0300, 5'h0, 1, 5, 32'h0000_0300, 0);

    // R12: stray completion and same-cycle accept/complete
    cur_req = "R12";
    complete(5);
    complete(5);
    set_req(12'h0AB, 32'h0, 5'h0); done_valid = 1; done_id = 3'd5;
    cycle();
    set_req(12'h0AB, 32'h0, 5'h0); done_valid = 1; done_id = 3'd5;
    cycle();

    // R10: bridge passthrough vs shared user
    cur_req = "R10";
    complete(4); complete(4); complete(5); complete(6); complete(7);
    cfg_dyn_we = 1; cfg_page = 2'd3; cfg_user = 5'h03;
    cycle();
    send_exp(12'h008, 32'h0000_0000, 5'h1F, 1, 4, 32'hC000_0000, 5'h1F);
    send_exp(12'h00B, 32'h0000_0010, 5'h1F, 1, 5, 32'hC000_0010, 5'h03);

    // R11: downstream back-pressure
    cur_req = "R11";
    out_ready = 0;
    set_req(12'h123, 32'h0, 5'h0);
    #1;
    chk(out_valid == 1'b1, "bp out_valid", out_valid, 1);
    chk(req_ready == 1'b0, "bp req_ready", req_ready, 0);
    cycle();
    out_ready = 1;

    // R8: saturation at 15 outstanding on fixed slot 3
    cur_req = "R8";
    for (int i = 0; i < 14; i++) begin
      set_req(12'h123, 32'h0, 5'h0);
      cycle();
    end
    set_req(12'h123, 32'h0, 5'h0);
    #1;
    chk(out_valid == 1'b0, "full out_valid", out_valid, 0);
    cycle();
    complete(3);

    // R11: random mix compared against the model
    cur_req = "R11";
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [11:0] ids [10] = '{12'h004, 12'h123, 12'h008, 12'h010, 12'h801,
                                12'h802, 12'h805, 12'h0F1, 12'h233, 12'h066};
      r = int'($urandom_range(0, 9));
      if ($urandom_range(0, 3) != 0) set_req(ids[r], $urandom, 5'($urandom));
      out_ready = ($urandom_range(0, 4) != 0);
      if ($urandom_range(0, 2) == 0) begin
        done_valid = 1; done_id = 3'($urandom_range(0, 7));
      end
      if ($urandom_range(0, 60) == 0) begin
        cfg_we = 1; cfg_slot = 3'($urandom_range(0, 7)); cfg_fixed = 1'($urandom);
        cfg_in_id = ids[$urandom_range(0, 9)]; cfg_page = 2'($urandom); cfg_user = 5'($urandom);
      end
      if ($urandom_range(0, 80) == 0) begin
        cfg_dyn_we = 1; cfg_page = 2'($urandom); cfg_user = 5'($urandom);
      end
      cycle();
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog R11: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule